// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block sits in a south bridge and connects the four active-low PCI interrupt pins (A, B, C and D) to a 16-line vector of active-high legacy IRQ requests. It feeds an interrupt controller. Each pin has its own routing byte in configuration space. The routing byte holds an enable flag and a 4-bit IRQ number. When the enable flag is set and the pin is asserted, the chosen IRQ line is raised. Several pins may share one IRQ line, and that line stays high while any of its sources is asserted.

The PCI pins are asynchronous to the block clock, so each one passes through a two-flop synchronizer before it is steered. The steered vector is registered. Four IRQ numbers are reserved for system use: 0, 2, 8 and 13. Routing a pin to one of them is stored in the routing byte, but it never raises that line.

The same configuration port returns the function's fixed identity bytes: vendor, device, command, revision and class code. Every other configuration byte reads as zero, and writes to those bytes do nothing.

Top module: `pirq_router`

## Requirements
- R1: While reset is asserted, and after it, the four routing bytes at 0x41..0x44 read 0x00 and `irqReq` is all zero.
- R2: The routing bytes for pins A, B, C and D are at 0x41, 0x42, 0x43 and 0x44. Bit 7 is the enable flag and bits 3:0 are the IRQ number. A read returns bit 7 and bits 3:0 as last written, with bits 6:4 always 0.
- R3: Identity reads return the following bytes: 0x00=0x39, 0x01=0x10, 0x02=0x08, 0x03=0x00, 0x04=0x07, 0x05=0x00, 0x08=0x00 (revision), 0x09=0x00, 0x0A=0x01 and 0x0B=0x06. Every address that is neither an identity byte nor a routing byte reads 0x00.
- R4: A write to any address outside 0x41..0x44 changes no readable byte and no output.
- R5: A pin that is enabled and driven low raises `irqReq[n]`, where n is its IRQ number. The line changes on the third rising edge after the pin changes: two synchronizer edges, then the output register.
- R6: A pin whose enable bit is 0 has no effect on `irqReq`.
- R7: An IRQ line is the OR of all enabled, asserted pins routed to it. The line falls only after the last of those pins is released.
- R8: `irqReq` bits 0, 2, 8 and 13 are never driven high, whatever the routing.
- R9: A new routing byte reaches `irqReq` one rising edge after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe, sampled on the rising edge |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWrData | input | 8 | Configuration write byte |
| cfgRdData | output | 8 | Configuration read byte, combinational from `cfgAddr` |
| pciIntN | input | 4 | Active-low PCI interrupt pins; bit 0 is pin A and bit 3 is pin D |
| irqReq | output | 16 | Active-high IRQ requests, bit n for IRQ n |

## Verification
Three latencies are checked.

- **Read data:** it is combinational, so the bench samples it one time step after it sets the address, away from any clock edge.
- **Routing writes:** a new routing byte is due one edge after its write edge. The bench checks that the old result still holds at the falling edge just after the write, and that the new one appears one cycle later.
- **Pin changes:** a pin change is due on the third edge. Directed steps check the output at the second and third falling edges after the change. Random steps hold the pins steady for four cycles before comparing the output with a bench model of the OR-steering and the reserved mask.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PIN_COUNT = 4;
  localparam int CFG_AW    = 8;
  localparam int CFG_DW    = 8;

  // strobes from the decode side to the routing datapath
  typedef struct packed {
    logic [PIN_COUNT-1:0] routeWr;
    logic [CFG_DW-1:0]    wrByte;
  } cfgStrobe_t;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter logic [CFG_AW-1:0] ROUTE_BASE = 8'h41,
  parameter logic [15:0]       VENDOR_ID  = 16'h1039,
  parameter logic [15:0]       DEVICE_ID  = 16'h0008,
  parameter logic [15:0]       CMD_INIT   = 16'h0007,
  parameter logic [7:0]        REV_ID     = 8'h00,
  parameter logic [23:0]       CLASS_CODE = 24'h060100
) (
  input  logic                              cfgWrEn,
  input  logic [CFG_AW-1:0]                 cfgAddr,
  input  logic [CFG_DW-1:0]                 cfgWrData,
  input  logic [PIN_COUNT-1:0][CFG_DW-1:0]  routeView,
  output cfgStrobe_t                        strobe,
  output logic [CFG_DW-1:0]                 cfgRdData
);
  // one write strobe per routing byte (R2, R4)
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_dec
    localparam logic [CFG_AW-1:0] PIN_ADDR = ROUTE_BASE + CFG_AW'(p);
    assign strobe.routeWr[p] = cfgWrEn && (cfgAddr == PIN_ADDR);
  end
  assign strobe.wrByte = cfgWrData;

  // read mux: identity bytes at standard header offsets (R3), routing bytes (R2)
  always_comb begin
    cfgRdData = '0;
    case (cfgAddr)
      8'h00: cfgRdData = VENDOR_ID[7:0];
      8'h01: cfgRdData = VENDOR_ID[15:8];
      8'h02: cfgRdData = DEVICE_ID[7:0];
      8'h03: cfgRdData = DEVICE_ID[15:8];
      8'h04: cfgRdData = CMD_INIT[7:0];
      8'h05: cfgRdData = CMD_INIT[15:8];
      8'h08: cfgRdData = REV_ID;
      8'h09: cfgRdData = CLASS_CODE[7:0];
      8'h0A: cfgRdData = CLASS_CODE[15:8];
      8'h0B: cfgRdData = CLASS_CODE[23:16];
      default: begin
        for (int p = 0; p < PIN_COUNT; p++)
          if (cfgAddr == ROUTE_BASE + CFG_AW'(p)) cfgRdData = routeView[p];
      end
    endcase
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int IRQ_COUNT = 16,
  parameter logic [IRQ_COUNT-1:0] RESERVED_MASK = 16'h2105,
  localparam int IRQ_SEL_W = $clog2(IRQ_COUNT)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  cfgStrobe_t                        strobe,
  input  logic [PIN_COUNT-1:0]              pinN,
  output logic [PIN_COUNT-1:0][CFG_DW-1:0]  routeView,
  output logic [IRQ_COUNT-1:0]              irqReq
);
  localparam int EN_BIT = CFG_DW - 1;

  logic [PIN_COUNT-1:0]                 routeEn;
  logic [PIN_COUNT-1:0][IRQ_SEL_W-1:0]  routeSel;
  logic [PIN_COUNT-1:0]                 syncA, syncB;
  logic [IRQ_COUNT-1:0]                 irqNext;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    // routing byte storage (R1, R2)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        routeEn[p]  <= 1'b0;
        routeSel[p] <= '0;
      end else if (strobe.routeWr[p]) begin
        routeEn[p]  <= strobe.wrByte[EN_BIT];
        routeSel[p] <= strobe.wrByte[IRQ_SEL_W-1:0];
      end
    end

    always_comb begin
      routeView[p]                = '0;
      routeView[p][EN_BIT]        = routeEn[p];
      routeView[p][IRQ_SEL_W-1:0] = routeSel[p];
    end

    // two-flop synchronizer, resets to deasserted (high)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncA[p] <= 1'b1;
        syncB[p] <= 1'b1;
      end else begin
        syncA[p] <= pinN[p];
        syncB[p] <= syncA[p];
      end
    end
  end

  // OR-steering of enabled, asserted pins (R5..R7), reserved lines masked (R8)
  always_comb begin
    irqNext = '0;
    for (int p = 0; p < PIN_COUNT; p++)
      for (int j = 0; j < IRQ_COUNT; j++)
        if (routeEn[p] && !syncB[p] && (routeSel[p] == IRQ_SEL_W'(j)))
          irqNext[j] = 1'b1;
    irqNext = irqNext & ~RESERVED_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqReq <= '0;
    else        irqReq <= irqNext;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int IRQ_COUNT = 16,
  parameter logic [IRQ_COUNT-1:0] RESERVED_MASK = 16'h2105,
  parameter logic [CFG_AW-1:0] ROUTE_BASE = 8'h41
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWrEn,
  input  logic [CFG_AW-1:0]     cfgAddr,
  input  logic [CFG_DW-1:0]     cfgWrData,
  output logic [CFG_DW-1:0]     cfgRdData,
  input  logic [PIN_COUNT-1:0]  pciIntN,
  output logic [IRQ_COUNT-1:0]  irqReq
);
  cfgStrobe_t                        strobe;
  logic [PIN_COUNT-1:0][CFG_DW-1:0]  routeView;

  pirq_ctrl #(.ROUTE_BASE(ROUTE_BASE)) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .routeView (routeView),
    .strobe    (strobe),
    .cfgRdData (cfgRdData)
  );

  pirq_datapath #(.IRQ_COUNT(IRQ_COUNT), .RESERVED_MASK(RESERVED_MASK)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .pinN      (pciIntN),
    .routeView (routeView),
    .irqReq    (irqReq)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_pkg::*;
#(
  parameter int IRQ_COUNT = 16,
  parameter logic [IRQ_COUNT-1:0] RESERVED_MASK = 16'h2105,
  parameter logic [CFG_AW-1:0] ROUTE_BASE = 8'h41
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CFG_AW-1:0]    cfgAddr,
  input logic [CFG_DW-1:0]    cfgRdData,
  input logic [PIN_COUNT-1:0] pciIntN,
  input logic [IRQ_COUNT-1:0] irqReq
);
  localparam logic [CFG_AW-1:0] ROUTE_LAST = ROUTE_BASE + CFG_AW'(PIN_COUNT - 1);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> irqReq == '0);

  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq & RESERVED_MASK) == '0);

  a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAddr >= ROUTE_BASE && cfgAddr <= ROUTE_LAST) |-> cfgRdData[6:4] == 3'b000);

  a_r3_vendor_low: assert property (@(posedge clk) disable iff (!rst_n)
    cfgAddr == 8'h00 |-> cfgRdData == 8'h39);

  a_r7_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(pciIntN, 3)) |-> irqReq == '0);

  a_r7_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irqReq) <= PIN_COUNT);
endmodule

bind pirq_router pirq_router_chk #(
  .IRQ_COUNT(IRQ_COUNT), .RESERVED_MASK(RESERVED_MASK), .ROUTE_BASE(ROUTE_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgAddr(cfgAddr), .cfgRdData(cfgRdData),
  .pciIntN(pciIntN), .irqReq(irqReq)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic [3:0]  pciIntN = 4'hF;
  logic [15:0] irqReq;

  int vecs = 0;
  int errs = 0;
  logic [7:0] mRoute [4];
  logic [7:0] rd;
  logic done = 1'b0;

  localparam logic [15:0] RESV = 16'h2105;

  always #2.5 clk = ~clk;

  pirq_router u_pirq_router (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .pciIntN(pciIntN), .irqReq(irqReq)
  );

  function automatic logic [15:0] expIrq(input logic [3:0] pins);
    logic [15:0] v = '0;
    for (int p = 0; p < 4; p++)
      if (mRoute[p][7] && !pins[p]) v[mRoute[p][3:0]] = 1'b1;
    return v & ~RESV;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a >= 8'h41 && a <= 8'h44) mRoute[a - 8'h41] = d & 8'h8F;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [7:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] idA [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0A, 8'h0B};
    logic [7:0] idV [10] = '{8'h39, 8'h10, 8'h08, 8'h00, 8'h07, 8'h00, 8'h00, 8'h00, 8'h01, 8'h06};
    logic [7:0] hole [6] = '{8'h06, 8'h07, 8'h10, 8'h40, 8'h45, 8'hFF};
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) mRoute[p] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irqReq, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irqReq, 16'h0);
    for (int p = 0; p < 4; p++) begin
      cfgRead(8'h41 + 8'(p), rd);
      chk("R1 route reset", {8'h0, rd}, 16'h0);
    end

    // R3 identity and unmapped reads
    for (int i = 0; i < 10; i++) begin
      cfgRead(idA[i], rd);
      chk("R3 identity", {8'h0, rd}, {8'h0, idV[i]});
    end
    for (int i = 0; i < 6; i++) begin
      cfgRead(hole[i], rd);
      chk("R3 unmapped zero", {8'h0, rd}, 16'h0);
    end

    // R4 writes outside routing bytes ignored
    @(negedge clk);
    cfgWrite(8'h00, 8'hFF);
    cfgWrite(8'h0A, 8'hFF);
    cfgWrite(8'h45, 8'h85);
    cfgWrite(8'h40, 8'h85);
    cfgRead(8'h00, rd); chk("R4 vendor kept", {8'h0, rd}, 16'h0039);
    cfgRead(8'h0A, rd); chk("R4 class kept", {8'h0, rd}, 16'h0001);
    cfgRead(8'h45, rd); chk("R4 hole kept", {8'h0, rd}, 16'h0);
    pciIntN = 4'h0;
    settle();
    chk("R4 no irq from ignored writes", irqReq, 16'h0);
    chk("R6 disabled pins quiet", irqReq, 16'h0);
    pciIntN = 4'hF;
    settle();

    // R2 readback masking
    @(negedge clk);
    cfgWrite(8'h41, 8'hFF);
    cfgRead(8'h41, rd); chk("R2 readback A", {8'h0, rd}, 16'h008F);
    cfgWrite(8'h44, 8'h7A);
    cfgRead(8'h44, rd); chk("R2 readback D", {8'h0, rd}, 16'h000A);

    // R5 latency: A -> IRQ5
    @(negedge clk);
    cfgWrite(8'h41, 8'h85);
    settle();
    pciIntN = 4'b1110;
    @(negedge clk);
    @(negedge clk);
    chk("R5 not yet after two edges", irqReq, 16'h0);
    @(negedge clk);
    chk("R5 raised on third edge", irqReq, 16'h0020);

    // R9 reroute takes one edge
    cfgWrite(8'h41, 8'h87);
    chk("R9 old route at write edge", irqReq, 16'h0020);
    @(negedge clk);
    chk("R9 new route next edge", irqReq, 16'h0080);

    // R6 clear enable
    cfgWrite(8'h41, 8'h07);
    @(negedge clk);
    chk("R6 disabled pin", irqReq, 16'h0);

    // R7 sharing: A and B onto IRQ10
    cfgWrite(8'h41, 8'h8A);
    cfgWrite(8'h42, 8'h8A);
    pciIntN = 4'b1100;
    settle();
    chk("R7 shared both", irqReq, 16'h0400);
    pciIntN = 4'b1101;
    settle();
    chk("R7 shared one left", irqReq, 16'h0400);
    pciIntN = 4'b1111;
    settle();
    chk("R7 shared released", irqReq, 16'h0);

    // R8 reserved lines
    cfgWrite(8'h41, 8'h80);
    cfgWrite(8'h42, 8'h82);
    cfgWrite(8'h43, 8'h88);
    cfgWrite(8'h44, 8'h8D);
    pciIntN = 4'h0;
    settle();
    chk("R8 reserved suppressed", irqReq, 16'h0);
    cfgRead(8'h44, rd); chk("R8 reserved stored", {8'h0, rd}, 16'h008D);
    pciIntN = 4'hF;
    settle();

    // random mix against the model (R5, R6, R7, R8)
    for (int it = 0; it < 300; it++) begin
      cfgWrite(8'h41 + 8'($urandom_range(0, 3)), 8'($urandom));
      pciIntN = 4'($urandom);
      settle();
      chk("R7 random steering", irqReq, expIrq(pciIntN));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule